// File: doc/BRIEF.md
# Dual-Bank Byte-Addressed GPIO Controller

This block is a general-purpose I/O controller reached over a small 8-bit I/O bus. Its pins are split at a parameterized boundary into a lower bank and an upper bank, meant for two different power wells. Each bank has three kinds of per-pin state: a pin enable, a direction and a level. Each kind is packed eight pins to a byte, and the upper bank's registers sit at a fixed 0x20 above the lower bank's. Upper-bank pins are renumbered from the boundary, so that pin SPLIT is local index 0 of the upper bank.

A host changes one pin by reading its byte, changing one bit and writing the byte back. For each pin the controller drives a pad output enable and a pad output value for a tristate pad. Pad inputs pass through a two-flop synchronizer and are returned when the level byte of an input pin is read. While a pin is an input, its stored output level cannot be changed. Software therefore has to turn a pin into an output before it sets the pin's level.

The lower bank must hold at least one pin, the upper bank must hold at least one pin, and neither bank may hold more than 32 pins.

Top module: `dual_bank_gpio`

## Requirements
- R1: Address bit 5 selects the bank: 0 selects the lower bank (pins 0 to SPLIT-1), and 1 selects the upper bank (pins SPLIT to NUM_PINS-1, local index = pin - SPLIT). Address bits 3:2 select the register kind: 0 is enable, 1 is direction, 2 is level. Address bits 1:0 select the byte, which equals the local index divided by 8. The bit within the data byte is the local index modulo 8.
- R2: A direction bit of 0 makes the pin an output. A level write to an output pin sets the driven value.
- R3: pad_oe_o[p] is 1 exactly when pin p has enable 1 and direction 0. pad_out_o[p] always equals the stored level of pin p.
- R4: A level write to a pin whose direction bit is 1 (input) leaves its stored level unchanged. The old value is still driven once the pin later becomes an output.
- R5: A level read returns the pad input, through a two-flop synchronizer, for input pins and the stored driven value for output pins.
- R6: Reset sets every direction bit to 1 and every level bit to 0, loads the enable bits from EN_RST_MASK, and clears rdata_o.
- R7: Some addresses are unimplemented: those with bit 4 set, and those with bits 3:2 equal to 3. Reads from them return 0 and writes to them are ignored. Bit positions beyond a bank's pin count also read 0 and ignore writes.
- R8: rdata_o is loaded on the clock edge that samples rd_i and holds its value otherwise. A write changes state on the edge that samples wr_i.
- R9: SPLIT and NUM_PINS are parameters. The two banks together cover exactly NUM_PINS pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | I/O register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pad_in_i | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_oe_o | output | NUM_PINS | Per-pin pad output enable |
| pad_out_o | output | NUM_PINS | Per-pin pad output value |

## Verification
Timing of results:
- A write is visible on pad_oe_o and pad_out_o one clock edge after the strobe is sampled.
- Read data appears on rdata_o at the same edge that samples the read strobe.
- A change on a pad input reaches the level readback after two edges, so a read issued after those two edges returns it.

How the bench keeps to this timing:
- It drives strobes at the falling edge and samples results at the next falling edge.
- It waits two full cycles after changing pad inputs before it issues a read.
- For the read and write timing it checks the outputs both just before and just after the sampling edge, so a result that arrives early or late is caught.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    GRP_EN   = 2'd0,
    GRP_DIR  = 2'd1,
    GRP_LVL  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam int unsigned ADDR_W        = 6;
  localparam int unsigned BYTES_PER_GRP = 4;
  localparam int unsigned BANK_MAX_PINS = 8 * BYTES_PER_GRP;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= d_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned          BANK_PINS = 8,
  parameter logic [BANK_PINS-1:0] EN_RST    = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  grp_e                 grp_i,
  input  logic [1:0]           byte_i,
  input  logic [7:0]           wdata_i,
  input  logic [BANK_PINS-1:0] pin_in_i,
  output logic [BANK_PINS-1:0] en_o,
  output logic [BANK_PINS-1:0] dir_o,
  output logic [BANK_PINS-1:0] lvl_o,
  output logic [7:0]           rd_byte_o
);
  localparam int unsigned VW = BANK_MAX_PINS;

  logic [BANK_PINS-1:0] en_q, dir_q, lvl_q, lvl_rd;
  logic [VW-1:0]        en_v, dir_v, lvl_v;
  logic [4:0]           base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= EN_RST;
      dir_q <= '1;
      lvl_q <= '0;
    end else if (wr_i) begin
      for (int p = 0; p < BANK_PINS; p++) begin
        if (byte_i == 2'(p / 8)) begin
          case (grp_i)
            GRP_EN:  en_q[p]  <= wdata_i[3'(p % 8)];
            GRP_DIR: dir_q[p] <= wdata_i[3'(p % 8)];
            // level is read-only while the pin is an input
            GRP_LVL: if (!dir_q[p]) lvl_q[p] <= wdata_i[3'(p % 8)];
            default: ;
          endcase
        end
      end
    end
  end

  assign lvl_rd = (dir_q & pin_in_i) | (~dir_q & lvl_q);

  always_comb begin
    en_v  = '0;
    dir_v = '0;
    lvl_v = '0;
    en_v[BANK_PINS-1:0]  = en_q;
    dir_v[BANK_PINS-1:0] = dir_q;
    lvl_v[BANK_PINS-1:0] = lvl_rd;
  end

  assign base = {byte_i, 3'b000};

  always_comb begin
    case (grp_i)
      GRP_EN:  rd_byte_o = en_v[base +: 8];
      GRP_DIR: rd_byte_o = dir_v[base +: 8];
      GRP_LVL: rd_byte_o = lvl_v[base +: 8];
      default: rd_byte_o = 8'h00;
    endcase
  end

  assign en_o  = en_q;
  assign dir_o = dir_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/dual_bank_gpio.sv
module dual_bank_gpio
  import gpio_pkg::*;
#(
  parameter int unsigned         NUM_PINS    = 14,
  parameter int unsigned         SPLIT       = 10,
  parameter logic [NUM_PINS-1:0] EN_RST_MASK = 14'h007F
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o
);
  localparam int unsigned LO_PINS = SPLIT;
  localparam int unsigned HI_PINS = NUM_PINS - SPLIT;

  initial begin
    if (LO_PINS < 1 || HI_PINS < 1 || LO_PINS > BANK_MAX_PINS || HI_PINS > BANK_MAX_PINS)
      $error("dual_bank_gpio: illegal SPLIT/NUM_PINS");
  end

  logic          hi_sel, in_win;
  grp_e          grp;
  logic [1:0]    byte_idx;
  logic [NUM_PINS-1:0] pin_s;

  assign hi_sel   = addr_i[5];
  assign in_win   = !addr_i[4];
  assign grp      = grp_e'(addr_i[3:2]);
  assign byte_idx = addr_i[1:0];

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_s)
  );

  logic [LO_PINS-1:0] en_lo, dir_lo, lvl_lo;
  logic [HI_PINS-1:0] en_hi, dir_hi, lvl_hi;
  logic [7:0]         rd_lo, rd_hi, rd_mux;

  gpio_bank #(.BANK_PINS(LO_PINS), .EN_RST(EN_RST_MASK[LO_PINS-1:0])) i_bank_lo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i && in_win && !hi_sel),
    .grp_i     (grp),
    .byte_i    (byte_idx),
    .wdata_i   (wdata_i),
    .pin_in_i  (pin_s[LO_PINS-1:0]),
    .en_o      (en_lo),
    .dir_o     (dir_lo),
    .lvl_o     (lvl_lo),
    .rd_byte_o (rd_lo)
  );

  gpio_bank #(.BANK_PINS(HI_PINS), .EN_RST(EN_RST_MASK[NUM_PINS-1:LO_PINS])) i_bank_hi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i && in_win && hi_sel),
    .grp_i     (grp),
    .byte_i    (byte_idx),
    .wdata_i   (wdata_i),
    .pin_in_i  (pin_s[NUM_PINS-1:LO_PINS]),
    .en_o      (en_hi),
    .dir_o     (dir_hi),
    .lvl_o     (lvl_hi),
    .rd_byte_o (rd_hi)
  );

  assign rd_mux = !in_win ? 8'h00 : (hi_sel ? rd_hi : rd_lo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 8'h00;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign pad_oe_o  = {en_hi & ~dir_hi, en_lo & ~dir_lo};
  assign pad_out_o = {lvl_hi, lvl_lo};
endmodule

// File: rtl/dual_bank_gpio_chk.sv
module dual_bank_gpio_chk #(
  parameter int unsigned NUM_PINS = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [5:0]          addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [7:0]          rdata_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o
);
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R7
  win_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[4]) |=> (rdata_o == 8'h00));

  // R7
  grp_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[3:2] == 2'd3) |=> (rdata_o == 8'h00));

  // R8
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pad_oe_o));

  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pad_out_o));

  // R7
  bad_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i[4] || addr_i[3:2] == 2'd3)) |=> ($stable(pad_oe_o) && $stable(pad_out_o)));
endmodule

bind dual_bank_gpio dual_bank_gpio_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o)
);

// File: tb/test_dual_bank_gpio.sv
module test_dual_bank_gpio;
  localparam int NP = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_bank_gpio #(.NUM_PINS(NP), .SPLIT(10), .EN_RST_MASK(14'h007F)) i_dual_bank_gpio (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // {is_wr, addr, data, expected read, requirement number}
  localparam int NV = 26;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 6'h00, 8'h00, 8'h7F, 4'd6},  // R6 enable reset mask
    {1'b1, 6'h10, 8'h00, 8'h00, 4'd7},  // R7 write outside window
    {1'b0, 6'h00, 8'h00, 8'h7F, 4'd7},  // R7 enable untouched
    {1'b0, 6'h01, 8'h00, 8'h00, 4'd6},
    {1'b0, 6'h04, 8'h00, 8'hFF, 4'd6},  // R6 all inputs
    {1'b0, 6'h05, 8'h00, 8'h03, 4'd7},  // R7 pins beyond bank read 0
    {1'b0, 6'h24, 8'h00, 8'h0F, 4'd1},  // R1 upper bank has 4 pins
    {1'b0, 6'h08, 8'h00, 8'h00, 4'd5},
    {1'b1, 6'h08, 8'hFF, 8'h00, 4'd4},  // R4 level write on inputs
    {1'b1, 6'h04, 8'hF0, 8'h00, 4'd2},  // R2 pins 0-3 outputs
    {1'b0, 6'h08, 8'h00, 8'h00, 4'd4},  // R4 stored level still 0
    {1'b1, 6'h08, 8'hA5, 8'h00, 4'd2},
    {1'b0, 6'h08, 8'h00, 8'h05, 4'd5},  // R5 outputs read driven value
    {1'b1, 6'h24, 8'h00, 8'h00, 4'd1},
    {1'b1, 6'h28, 8'hFF, 8'h00, 4'd1},
    {1'b0, 6'h28, 8'h00, 8'h0F, 4'd7},  // R7 only 4 bits exist
    {1'b1, 6'h0C, 8'hFF, 8'h00, 4'd7},
    {1'b0, 6'h0C, 8'h00, 8'h00, 4'd7},
    {1'b0, 6'h2C, 8'h00, 8'h00, 4'd7},
    {1'b0, 6'h10, 8'h00, 8'h00, 4'd7},
    {1'b1, 6'h21, 8'hFF, 8'h00, 4'd7},
    {1'b0, 6'h21, 8'h00, 8'h00, 4'd7},
    {1'b1, 6'h20, 8'h03, 8'h00, 4'd1},
    {1'b0, 6'h20, 8'h00, 8'h03, 4'd1},  // R1 upper enable
    {1'b0, 6'h00, 8'h00, 8'h7F, 4'd1},  // R1 lower bank unaffected
    {1'b0, 6'h09, 8'h00, 8'h00, 4'd9}   // R9 pins 8,9 inputs, pad 0
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R6 outputs during reset
    check("R6 oe in reset", 16'(pad_oe), 16'h0000);
    check("R6 rdata in reset", 16'(rdata), 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) begin
        bus_wr(VEC[i][25:20], VEC[i][19:12]);
      end else begin
        bus_rd(VEC[i][25:20], d);
        check($sformatf("R%0d vec %0d", VEC[i][3:0], i), 16'(d), 16'(VEC[i][11:4]));
      end
    end

    // R3 pad controls
    check("R3 pad_oe", 16'(pad_oe), 16'h0C0F);
    check("R3 pad_out", 16'(pad_out), 16'h3C05);

    // R5 synchronized pad input
    @(negedge clk); pad_in = 14'h0022;
    repeat (2) @(negedge clk);
    bus_rd(6'h08, d);
    check("R5 level mix", 16'(d), 16'h0025);

    // R4 ignored write kept after switch to output
    bus_wr(6'h08, 8'h15);
    bus_wr(6'h04, 8'hE0);
    check("R4 pad_out", 16'(pad_out), 16'h3C05);
    check("R4 pad_oe", 16'(pad_oe), 16'h0C1F);

    // R2 output level write
    bus_wr(6'h08, 8'h15);
    check("R2 pad_out", 16'(pad_out), 16'h3C15);
    bus_rd(6'h08, d);
    check("R2 readback", 16'(d), 16'h0035);

    // R8 read timing
    @(negedge clk); addr = 6'h04; rd = 1'b1;
    check("R8 before edge", 16'(rdata), 16'h0035);
    @(posedge clk); #1;
    check("R8 after edge", 16'(rdata), 16'h00E0);
    @(negedge clk); rd = 1'b0; addr = 6'h00;
    @(negedge clk);
    check("R8 hold", 16'(rdata), 16'h00E0);

    // R8 write timing
    @(negedge clk); addr = 6'h00; wdata = 8'h00; wr = 1'b1;
    check("R8 wr before edge", 16'(pad_oe), 16'h0C1F);
    @(posedge clk); #1;
    check("R8 wr after edge", 16'(pad_oe), 16'h0C00);
    @(negedge clk); wr = 1'b0;

    // R6 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R6 oe", 16'(pad_oe), 16'h0000);
    check("R6 out", 16'(pad_out), 16'h0000);
    check("R6 rdata", 16'(rdata), 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_rd(6'h00, d);
    check("R6 enable", 16'(d), 16'h007F);
    bus_rd(6'h04, d);
    check("R6 dir", 16'(d), 16'h00FF);
    bus_rd(6'h08, d);
    check("R6 level inputs", 16'(d), 16'h0022);
    bus_rd(6'h28, d);
    check("R6 upper level", 16'(d), 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule